// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block watches a clock of unknown health against a trusted reference clock. While enabled, it runs back-to-back measurement windows. Each window lasts a programmable number of reference-clock cycles. In each window it counts the edges of the monitored clock, and when the window closes it compares the count against an upper limit and a lower limit. A result above the upper limit, or below the lower limit, latches a sticky flag. Flags whose enables are set raise one of two interrupt lines.

Software reaches the block through a small register port on the bus clock. That port holds the enable, the window length, the two limits, the interrupt enables, and a status word. The status word carries the two flags and a running indication. A typical sequence is: program the window and limits, set the enable, poll until the running bit reads 1, and service interrupts by writing ones to the flags. To stop, clear the enable and wait for the running bit to drop.

The monitored edge count is kept by a Gray-coded counter in the monitored domain and read in the reference domain. The enable goes into the reference domain through a two-flop synchronizer. Window results and the running state come back to the bus domain through two-flop synchronizers, with toggle encoding for the results.

Top module: `freqwin_monitor`

## Requirements
- R1: After reset every register reads zero, and both `irq` and `irq_alt` are low.
- R2: The registers sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, and each register reads back only its own field, zero-extended to 32 bits:
  - 0x00 is control, with the enable in bit 0.
  - 0x04 holds the window units, WIN_W bits.
  - 0x08 holds the upper limit, CW bits.
  - 0x0C holds the lower limit, CW bits.
  - 0x10 holds the interrupt enables in bits 3:0.
  - 0x14 is status.
  - An access whose address has bits 1:0 nonzero writes nothing and reads zero.
- R3: A window lasts 10 × N reference-clock cycles, where N is the window-units value. N = 0 is treated as 1.
- R4: When a window closes, a count above the upper limit sets the too-high flag (status bit 1). A count below the lower limit sets the too-low flag (status bit 0). A count within the limits, inclusive, sets neither flag.
- R5: A flag stays set until software writes 1 to its status bit. Writing 0 to a flag's bit leaves that flag unchanged.
- R6: `irq` = (too-low AND enable bit 0) OR (too-high AND enable bit 1). `irq_alt` = (too-low AND enable bit 2) OR (too-high AND enable bit 3). A flag latches even when its enables are clear.
- R7: Status bit 8 (running) reads 0 right after the enable is written. It reads 1 only once the enable has crossed into the reference domain and measurement has begun. It returns to 0 within a few reference cycles after the enable is cleared.
- R8: If the monitored clock stops, windows still close on the reference clock with a count of zero, which sets the too-low flag.
- R9: While the enable is clear, no window closes and no flag is set, whatever the monitored clock does.
- R10: The monitored count crosses into the reference domain as a Gray code that changes by at most one bit per monitored edge, so counts stay accurate when the monitored clock is faster than the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| ref_clk | input | 1 | Trusted reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| mon_clk | input | 1 | Clock under observation |
| mon_rst_n | input | 1 | Active-low asynchronous reset, monitored domain |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt from flags gated by enable bits 1:0 |
| irq_alt | output | 1 | Interrupt from flags gated by enable bits 3:2 |

## Verification
On every cycle, the assertions check the following:
- a flag drops only when a write-one to status targets it;
- a flag rises only on a window result arriving from the reference domain;
- an interrupt line stays low while its enables are zero;
- the running state starts only from a synchronized enable and falls after the enable is withdrawn;
- the Gray counter steps one bit at a time.

Only the bench scenarios can show that the measured counts are right for a given frequency ratio. The same holds for the ×10 window scaling and the zero-count result of a halted clock. Those checks depend on real clock ratios and on several windows elapsing.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  localparam int unsigned WIN_SCALE = 10;

  typedef enum logic [2:0] {
    RI_CTRL = 3'd0,
    RI_WIN  = 3'd1,
    RI_HI   = 3'd2,
    RI_LO   = 3'd3,
    RI_IEN  = 3'd4,
    RI_STAT = 3'd5
  } reg_idx_e;

  localparam int unsigned ST_LO_BIT  = 0;
  localparam int unsigned ST_HI_BIT  = 1;
  localparam int unsigned ST_RUN_BIT = 8;

  localparam int unsigned IE_LO     = 0;
  localparam int unsigned IE_HI     = 1;
  localparam int unsigned IE_LO_ALT = 2;
  localparam int unsigned IE_HI_ALT = 3;

  // Window length in reference cycles for a programmed unit count
  function automatic logic [31:0] win_cycles(input logic [31:0] units);
    if (units == 32'd0) return 32'(WIN_SCALE);
    return units * 32'(WIN_SCALE);
  endfunction

endpackage

// File: rtl/fwm_sync2.sv
module fwm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fwm_gray_cnt.sv
module fwm_gray_cnt #(
  parameter int CW = 16
) (
  input  logic          mon_clk,
  input  logic          mon_rst_n,
  output logic [CW-1:0] gray_q
);
  logic [CW-1:0] bin_q;
  logic [CW-1:0] bin_nxt;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/fwm_window.sv
module fwm_window #(
  parameter int CW    = 16,
  parameter int WIN_W = 12
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             en_async,
  input  logic [CW-1:0]    gray_async,
  input  logic [WIN_W-1:0] win_units,
  input  logic [CW-1:0]    hi_thr,
  input  logic [CW-1:0]    lo_thr,
  output logic             en_ref,
  output logic             run_q,
  output logic             hi_evt,
  output logic             lo_evt,
  output logic [1:0]       evt_tog_q
);
  localparam int WCW = WIN_W + 4;

  function automatic logic [CW-1:0] gray2bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CW-1:0]  gray_s;
  logic [CW-1:0]  cur_cnt;
  logic [CW-1:0]  base_q;
  logic [CW-1:0]  meas;
  logic [WCW-1:0] win_len;
  logic [WCW-1:0] wcnt_q;
  logic           window_done;

  fwm_sync2 #(.W(1)) u_en_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(en_async), .q(en_ref)
  );

  fwm_sync2 #(.W(CW)) u_gray_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(gray_async), .q(gray_s)
  );

  assign cur_cnt     = gray2bin(gray_s);
  assign win_len     = WCW'(fwm_pkg::win_cycles(32'(win_units)));
  assign window_done = run_q & en_ref & (wcnt_q == (win_len - 1'b1));
  assign meas        = cur_cnt - base_q;
  assign hi_evt      = window_done & (meas > hi_thr);
  assign lo_evt      = window_done & (meas < lo_thr);

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      run_q     <= 1'b0;
      base_q    <= '0;
      wcnt_q    <= '0;
      evt_tog_q <= '0;
    end else begin
      if (!en_ref) begin
        run_q  <= 1'b0;
        wcnt_q <= '0;
      end else if (!run_q) begin
        run_q  <= 1'b1;
        base_q <= cur_cnt;
        wcnt_q <= '0;
      end else if (window_done) begin
        base_q <= cur_cnt;
        wcnt_q <= '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
      evt_tog_q <= evt_tog_q ^ {hi_evt, lo_evt};
    end
  end
endmodule

// File: rtl/fwm_regs.sv
module fwm_regs #(
  parameter int CW     = 16,
  parameter int WIN_W  = 12,
  parameter int ADDR_W = 5
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              run_async,
  input  logic [1:0]        evt_tog_async,
  output logic              ctrl_en,
  output logic [WIN_W-1:0]  win_units,
  output logic [CW-1:0]     hi_thr,
  output logic [CW-1:0]     lo_thr,
  output logic [3:0]        ien,
  output logic              flag_lo,
  output logic              flag_hi,
  output logic              lo_set,
  output logic              hi_set,
  output logic              irq,
  output logic              irq_alt
);
  import fwm_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic             run_s;
  logic [1:0]       tog_s;
  logic [1:0]       tog_prev_q;
  logic             aligned;
  logic             wr_ok;
  logic [IDX_W-1:0] idx;
  logic             clr_lo;
  logic             clr_hi;
  logic             unused_wdata;

  fwm_sync2 #(.W(1)) u_run_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(run_async), .q(run_s)
  );

  fwm_sync2 #(.W(2)) u_evt_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(evt_tog_async), .q(tog_s)
  );

  assign lo_set       = tog_s[0] ^ tog_prev_q[0];
  assign hi_set       = tog_s[1] ^ tog_prev_q[1];
  assign aligned      = (bus_addr[1:0] == 2'b00);
  assign idx          = bus_addr[ADDR_W-1:2];
  assign wr_ok        = bus_we & aligned;
  assign clr_lo       = wr_ok & (idx == IDX_W'(RI_STAT)) & bus_wdata[ST_LO_BIT];
  assign clr_hi       = wr_ok & (idx == IDX_W'(RI_STAT)) & bus_wdata[ST_HI_BIT];
  assign unused_wdata = ^bus_wdata[31:CW];

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ctrl_en    <= 1'b0;
      win_units  <= '0;
      hi_thr     <= '0;
      lo_thr     <= '0;
      ien        <= '0;
      flag_lo    <= 1'b0;
      flag_hi    <= 1'b0;
      tog_prev_q <= '0;
    end else begin
      tog_prev_q <= tog_s;
      if (wr_ok) begin
        case (idx)
          IDX_W'(RI_CTRL): ctrl_en   <= bus_wdata[0];
          IDX_W'(RI_WIN):  win_units <= bus_wdata[WIN_W-1:0];
          IDX_W'(RI_HI):   hi_thr    <= bus_wdata[CW-1:0];
          IDX_W'(RI_LO):   lo_thr    <= bus_wdata[CW-1:0];
          IDX_W'(RI_IEN):  ien       <= bus_wdata[3:0];
          default: ;
        endcase
      end
      // a fresh result wins over a same-cycle clear
      flag_lo <= lo_set | (flag_lo & ~clr_lo);
      flag_hi <= hi_set | (flag_hi & ~clr_hi);
    end
  end

  assign irq     = (flag_lo & ien[IE_LO])     | (flag_hi & ien[IE_HI]);
  assign irq_alt = (flag_lo & ien[IE_LO_ALT]) | (flag_hi & ien[IE_HI_ALT]);

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(RI_CTRL): bus_rdata[0]         = ctrl_en;
        IDX_W'(RI_WIN):  bus_rdata[WIN_W-1:0] = win_units;
        IDX_W'(RI_HI):   bus_rdata[CW-1:0]    = hi_thr;
        IDX_W'(RI_LO):   bus_rdata[CW-1:0]    = lo_thr;
        IDX_W'(RI_IEN):  bus_rdata[3:0]       = ien;
        IDX_W'(RI_STAT): begin
          bus_rdata[ST_LO_BIT]  = flag_lo;
          bus_rdata[ST_HI_BIT]  = flag_hi;
          bus_rdata[ST_RUN_BIT] = run_s;
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/freqwin_monitor.sv
module freqwin_monitor #(
  parameter int CW     = 16,
  parameter int WIN_W  = 12,
  parameter int ADDR_W = 5
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              mon_clk,
  input  logic              mon_rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              irq_alt
);
  // named internal events, observed by the bound checker
  logic             ctrl_en_w;
  logic [WIN_W-1:0] win_units_w;
  logic [CW-1:0]    hi_thr_w;
  logic [CW-1:0]    lo_thr_w;
  logic [3:0]       ien_w;
  logic             flag_lo_w;
  logic             flag_hi_w;
  logic             lo_set_w;
  logic             hi_set_w;
  logic             en_ref_w;
  logic             run_ref_w;
  logic             hi_evt_w;
  logic             lo_evt_w;
  logic [1:0]       evt_tog_w;
  logic [CW-1:0]    mon_gray_w;

  fwm_gray_cnt #(.CW(CW)) u_cnt (
    .mon_clk(mon_clk), .mon_rst_n(mon_rst_n), .gray_q(mon_gray_w)
  );

  fwm_window #(.CW(CW), .WIN_W(WIN_W)) u_win (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .en_async(ctrl_en_w), .gray_async(mon_gray_w),
    .win_units(win_units_w), .hi_thr(hi_thr_w), .lo_thr(lo_thr_w),
    .en_ref(en_ref_w), .run_q(run_ref_w),
    .hi_evt(hi_evt_w), .lo_evt(lo_evt_w), .evt_tog_q(evt_tog_w)
  );

  fwm_regs #(.CW(CW), .WIN_W(WIN_W), .ADDR_W(ADDR_W)) u_regs (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .run_async(run_ref_w), .evt_tog_async(evt_tog_w),
    .ctrl_en(ctrl_en_w), .win_units(win_units_w),
    .hi_thr(hi_thr_w), .lo_thr(lo_thr_w), .ien(ien_w),
    .flag_lo(flag_lo_w), .flag_hi(flag_hi_w),
    .lo_set(lo_set_w), .hi_set(hi_set_w),
    .irq(irq), .irq_alt(irq_alt)
  );
endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
  parameter int CW     = 16,
  parameter int ADDR_W = 5
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              ref_clk,
  input logic              ref_rst_n,
  input logic              mon_clk,
  input logic              mon_rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        clr_bits,
  input logic              flag_lo,
  input logic              flag_hi,
  input logic              lo_set,
  input logic              hi_set,
  input logic [3:0]        ien,
  input logic              irq,
  input logic              irq_alt,
  input logic              en_ref,
  input logic              run_ref,
  input logic [CW-1:0]     mon_gray
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4 * int'(fwm_pkg::RI_STAT));

  // R5
  hi_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $fell(flag_hi) |-> $past(bus_we && bus_addr == STAT_ADDR && clr_bits[1]));

  // R5
  lo_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $fell(flag_lo) |-> $past(bus_we && bus_addr == STAT_ADDR && clr_bits[0]));

  // R4
  hi_rise_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(flag_hi) |-> $past(hi_set));

  // R4
  lo_rise_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(flag_lo) |-> $past(lo_set));

  // R6
  irq_quiet_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ien[1:0] == 2'b00) |-> !irq);

  // R6
  irq_alt_quiet_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ien[3:2] == 2'b00) |-> !irq_alt);

  // R7
  run_start_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(run_ref) |-> $past(en_ref));

  // R9
  run_stop_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !en_ref |=> !run_ref);

  // R10
  gray_step_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    $countones(mon_gray ^ $past(mon_gray)) <= 1);
endmodule

bind freqwin_monitor fwm_checker #(.CW(CW), .ADDR_W(ADDR_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
  .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
  .bus_we(bus_we), .bus_addr(bus_addr), .clr_bits(bus_wdata[1:0]),
  .flag_lo(flag_lo_w), .flag_hi(flag_hi_w),
  .lo_set(lo_set_w), .hi_set(hi_set_w),
  .ien(ien_w), .irq(irq), .irq_alt(irq_alt),
  .en_ref(en_ref_w), .run_ref(run_ref_w), .mon_gray(mon_gray_w)
);

// File: tb/sim_freqwin_monitor.sv
`timescale 1ns/1ps
module sim_freqwin_monitor;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_WIN  = 5'h04;
  localparam logic [4:0] A_HI   = 5'h08;
  localparam logic [4:0] A_LO   = 5'h0C;
  localparam logic [4:0] A_IEN  = 5'h10;
  localparam logic [4:0] A_STAT = 5'h14;

  logic bus_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic mon_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic mon_on  = 1'b1;
  real  mon_half = 5.0;

  logic        bus_we    = 1'b0;
  logic [4:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        irq_alt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4  bus_clk = ~bus_clk;   // 125 MHz
  always #10 ref_clk = ~ref_clk;   // 50 MHz reference
  always begin
    if (mon_on) begin
      #(mon_half) mon_clk = ~mon_clk;
    end else begin
      #3;
    end
  end

  freqwin_monitor u0 (
    .bus_clk(bus_clk), .bus_rst_n(rst_n),
    .ref_clk(ref_clk), .ref_rst_n(rst_n),
    .mon_clk(mon_clk), .mon_rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .irq_alt(irq_alt)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // stop, clear, program, start, let three windows pass, return status
  task automatic measure(input int units, input int lo, input int hi,
                         input real half, input bit on, output logic [31:0] st);
    int win_ns;
    wr(A_CTRL, 0);
    idle(40);
    wr(A_STAT, 32'h3);
    wr(A_WIN, units);
    wr(A_HI, hi);
    wr(A_LO, lo);
    mon_half = half;
    mon_on   = on;
    idle(20);
    wr(A_CTRL, 1);
    win_ns = 10 * ((units == 0) ? 1 : units) * 20;
    idle((3 * win_ns) / 8 + 60);
    rd(A_STAT, st);
    wr(A_CTRL, 0);
    idle(40);
    mon_on = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); check("R1", "ctrl after reset", d, 0);
    rd(A_WIN,  d); check("R1", "window after reset", d, 0);
    rd(A_HI,   d); check("R1", "upper limit after reset", d, 0);
    rd(A_LO,   d); check("R1", "lower limit after reset", d, 0);
    rd(A_IEN,  d); check("R1", "irq enables after reset", d, 0);
    rd(A_STAT, d); check("R1", "status after reset", d, 0);
    check("R1", "irq lines after reset", {30'd0, irq_alt, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_WIN, 32'hFFFF_FFFF); rd(A_WIN, d); check("R2", "window field width", d, 32'hFFF);
    wr(A_HI,  32'hFFFF_FFFF); rd(A_HI,  d); check("R2", "upper limit width", d, 32'hFFFF);
    wr(A_LO,  32'hABCD_1234); rd(A_LO,  d); check("R2", "lower limit width", d, 32'h1234);
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, d); check("R2", "irq enable width", d, 32'hF);
    wr(5'h09, 32'h0000_0055); rd(A_HI,  d); check("R2", "unaligned write ignored", d, 32'hFFFF);
    rd(5'h09, d); check("R2", "unaligned read zero", d, 0);
    wr(A_WIN, 0); wr(A_HI, 0); wr(A_LO, 0); wr(A_IEN, 0);
  endtask

  task automatic t_run();
    logic [31:0] d;
    wr(A_WIN, 10); wr(A_HI, 32'hFFFF); wr(A_LO, 0);
    wr(A_CTRL, 1);
    rd(A_STAT, d); check("R7", "running right after enable", d[8], 0);
    idle(40);
    rd(A_STAT, d); check("R7", "running after sync", d[8], 1);
    rd(A_CTRL, d); check("R2", "ctrl readback", d, 1);
    wr(A_CTRL, 0);
    idle(40);
    rd(A_STAT, d); check("R7", "running after disable", d[8], 0);
  endtask

  task automatic t_inrange();
    logic [31:0] st;
    measure(10, 180, 220, 5.0, 1, st);
    check("R4", "200 counts inside 180..220", st & 3, 0);
  endtask

  task automatic t_high();
    logic [31:0] st;
    measure(10, 180, 220, 4.0, 1, st);
    check("R4 R10", "250 counts above 220", st & 3, 2);
    check("R6", "flag latched, irqs off", {30'd0, irq_alt, irq}, 0);
  endtask

  task automatic t_irq();
    wr(A_IEN, 32'h2); check("R6", "irq from high enable", {30'd0, irq_alt, irq}, 32'h1);
    wr(A_IEN, 32'h8); check("R6", "irq_alt from high alt enable", {30'd0, irq_alt, irq}, 32'h2);
    wr(A_IEN, 32'h5); check("R6", "low enables with only high flag", {30'd0, irq_alt, irq}, 0);
    wr(A_IEN, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_STAT, 32'h0); rd(A_STAT, d); check("R5", "write 0 keeps flag", d & 3, 2);
    wr(A_STAT, 32'h1); rd(A_STAT, d); check("R5", "clearing other flag keeps flag", d & 3, 2);
    wr(A_STAT, 32'h2); rd(A_STAT, d); check("R5", "write 1 clears flag", d & 3, 0);
  endtask

  task automatic t_low();
    logic [31:0] st;
    measure(10, 180, 220, 7.0, 1, st);
    check("R4", "about 143 counts below 180", st & 3, 1);
  endtask

  task automatic t_stop();
    logic [31:0] st;
    measure(10, 180, 220, 5.0, 0, st);
    check("R8", "halted clock gives too-low", st & 3, 1);
  endtask

  task automatic t_window();
    logic [31:0] st;
    measure(1, 15, 25, 5.0, 1, st);
    check("R3", "10-cycle window: 20 counts", st & 3, 0);
    measure(0, 15, 25, 5.0, 1, st);
    check("R3", "zero units acts as one", st & 3, 0);
    measure(2, 15, 25, 5.0, 1, st);
    check("R3", "20-cycle window: 40 counts", st & 3, 2);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_STAT, 32'h3);
    wr(A_WIN, 1); wr(A_HI, 1); wr(A_LO, 1);
    mon_half = 4.0;
    idle(1000);
    rd(A_STAT, d); check("R9", "no flags while disabled", d, 0);
    check("R9", "no irq while disabled", {30'd0, irq_alt, irq}, 0);
  endtask

  initial begin
    idle(10);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_regs();
    t_run();
    t_inrange();
    t_high();
    t_irq();
    t_w1c();
    t_low();
    t_stop();
    t_window();
    t_disabled();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule